// File: doc/BRIEF.md
# Multi-Channel Capture Edge Selector

This block is the channel-mode control and capture-trigger logic of a 16-bit timer that has two free-running counters. It holds one 16-bit mode register that software writes through a small byte-laned bus. Each of six external capture pins has a 2-bit code in that register. The code picks which transition of the pin counts as a capture event: falling, rising, both, or none. Four of the six channels can also be tied to either counter by one bit each. The outer two channels always use counter 0.

Each pin is first resynchronised by two flip-flops, then compared with its previous synchronised value. When the selected transition is seen, the block raises a one-clock strobe for that channel. On the same clock edge it loads the bound counter's value into that channel's capture register. The counters come in as plain buses. Compare-match, counter control and interrupt handling belong to neighbouring blocks.

A single-bit update is done by the bus master as a byte-lane write of the containing byte. The register sits at word offset 2: the low byte is at address 2 and the high byte at address 3.

Top module: `capture_edge_select`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the mode register reads 0, every capture strobe is 0 and every capture register is 0. So every pin starts in falling-edge mode and every channel starts bound to counter 0.
- R2: A write with `wrEn` high and `addr` equal to 2 or 3 updates bits 7:0 when `byteEn[0]` is 1 and bits 15:8 when `byteEn[1]` is 1. The other lane keeps its value. `rdData` always returns the whole 16-bit register.
- R3: Pin y is governed by register bits [2y+1:2y]. Code 2'b00 detects a falling edge, 2'b01 a rising edge, 2'b11 either edge, and 2'b10 detects nothing.
- R4: Let a pin value first be sampled at clock edge n, and let it differ from the value sampled at edge n-1. If that change matches the pin's code, the channel's strobe is high for exactly the cycle after edge n+2. No strobe is raised otherwise.
- R5: Channel m, for m from 1 to 4, captures from counter 1 when register bit 11+m is 1 and from counter 0 when it is 0. Channels 0 and 5 always capture from counter 0. The capture register takes the counter value present at the clock edge that raises the strobe, and it holds that value at all other times.
- R6: A register write first affects detection on the clock edge after the write edge. Changing a code does not by itself produce a strobe; only a real pin transition does.
- R7: A write to any address other than 2 or 3, or with both byte enables low, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Byte address of the access |
| byteEn | input | 2 | Byte-lane enables, bit 0 = low byte |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Full mode register value |
| capIn | input | 6 | Asynchronous capture pins |
| cnt0 | input | 16 | Counter 0 value |
| cnt1 | input | 16 | Counter 1 value |
| capStrobe | output | 6 | One-cycle capture event per channel |
| capValue | output | 96 | Capture registers, channel c at bits [16c+15:16c] |

## Verification
Two things can land on the same clock edge: a register write that changes a pin's edge code or a channel's counter binding, and a detection on that same channel. The bench provokes this by rewriting the register, with random and with hand-picked values, while every pin keeps toggling. Many detections therefore coincide with a write edge. The behavioural model in the bench is the judge. It always uses the code and binding that were in force before the write edge, and the outputs are compared on every clock.

// File: rtl/cesel_pkg.sv
package cesel_pkg;
  localparam int CESEL_NUM_IN = 6;

  // Per-channel strobes from the control side to the datapath.
  typedef struct packed {
    logic [CESEL_NUM_IN-1:0] fire;    // valid edge seen this cycle
    logic [CESEL_NUM_IN-1:0] useAlt;  // capture from counter 1
  } ctlStrobes_t;
endpackage

// File: rtl/cesel_ctrl.sv
module cesel_ctrl
  import cesel_pkg::*;
#(
  parameter int NUM_IN     = CESEL_NUM_IN,
  parameter int NUM_BOUND  = 4,
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [(2*NUM_IN+NUM_BOUND)/8-1:0] byteEn,
  input  logic [2*NUM_IN+NUM_BOUND-1:0]   wrData,
  input  logic [NUM_IN-1:0]               capIn,
  output logic [2*NUM_IN+NUM_BOUND-1:0]   modeReg,
  output ctlStrobes_t                     ctl
);
  localparam int EDGE_W    = 2 * NUM_IN;
  localparam int REG_W     = EDGE_W + NUM_BOUND;
  localparam int NUM_LANES = REG_W / 8;

  logic regHit;
  assign regHit = wrEn && ((addr >> 1) == ADDR_W'(REG_OFFSET >> 1));

  // Byte-laned mode register
  for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        modeReg[8*b +: 8] <= '0;
      else if (regHit && byteEn[b])
        modeReg[8*b +: 8] <= wrData[8*b +: 8];
    end
  end

  // Two-stage synchroniser plus history stage
  logic [NUM_IN-1:0] syncA, syncB, histQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      histQ <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      histQ <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_det
    logic [1:0] edgeCode;
    assign edgeCode = modeReg[2*i +: 2];

    always_comb begin
      unique case (edgeCode)
        2'b00:   ctl.fire[i] = histQ[i] & ~syncB[i];
        2'b01:   ctl.fire[i] = ~histQ[i] & syncB[i];
        2'b11:   ctl.fire[i] = histQ[i] ^ syncB[i];
        default: ctl.fire[i] = 1'b0;
      endcase
    end

    if (i >= 1 && i <= NUM_BOUND) begin : g_bound
      assign ctl.useAlt[i] = modeReg[EDGE_W + i - 1];
    end else begin : g_fixed
      assign ctl.useAlt[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cesel_dpath.sv
module cesel_dpath
  import cesel_pkg::*;
#(
  parameter int NUM_IN = CESEL_NUM_IN,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             ctl,
  input  logic [CNT_W-1:0]        cnt0,
  input  logic [CNT_W-1:0]        cnt1,
  output logic [NUM_IN-1:0]       capStrobe,
  output logic [NUM_IN*CNT_W-1:0] capValue
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        capStrobe[i]           <= 1'b0;
        capValue[i*CNT_W +: CNT_W] <= '0;
      end else begin
        capStrobe[i] <= ctl.fire[i];
        if (ctl.fire[i])
          capValue[i*CNT_W +: CNT_W] <= ctl.useAlt[i] ? cnt1 : cnt0;
      end
    end
  end
endmodule

// File: rtl/capture_edge_select.sv
module capture_edge_select
  import cesel_pkg::*;
#(
  parameter int NUM_IN     = CESEL_NUM_IN,
  parameter int NUM_BOUND  = 4,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 2,
  localparam int REG_W     = 2 * NUM_IN + NUM_BOUND,
  localparam int LANES     = REG_W / 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        byteEn,
  input  logic [REG_W-1:0]        wrData,
  output logic [REG_W-1:0]        rdData,
  input  logic [NUM_IN-1:0]       capIn,
  input  logic [CNT_W-1:0]        cnt0,
  input  logic [CNT_W-1:0]        cnt1,
  output logic [NUM_IN-1:0]       capStrobe,
  output logic [NUM_IN*CNT_W-1:0] capValue
);
  ctlStrobes_t ctl;

  cesel_ctrl #(
    .NUM_IN(NUM_IN), .NUM_BOUND(NUM_BOUND),
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .capIn(capIn), .modeReg(rdData), .ctl(ctl)
  );

  cesel_dpath #(
    .NUM_IN(NUM_IN), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cnt0(cnt0), .cnt1(cnt1),
    .capStrobe(capStrobe), .capValue(capValue)
  );
endmodule

// File: rtl/cesel_check.sv
module cesel_check #(
  parameter int NUM_IN    = 6,
  parameter int NUM_BOUND = 4,
  parameter int CNT_W     = 16,
  localparam int REG_W    = 2 * NUM_IN + NUM_BOUND
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [NUM_IN-1:0]       capIn,
  input logic [CNT_W-1:0]        cnt0,
  input logic [CNT_W-1:0]        cnt1,
  input logic [REG_W-1:0]        rdData,
  input logic [NUM_IN-1:0]       capStrobe,
  input logic [NUM_IN*CNT_W-1:0] capValue
);
  // R1: register and strobes are clear on the first clock out of reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (rdData == '0 && capStrobe == '0));

  // R7: without a write strobe the register holds
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
    // R4: a strobe follows a real pin transition three samples earlier
    a_r4_pin_changed: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe[i] |-> ($past(capIn[i], 3) != $past(capIn[i], 4)));

    // R3: code 2'b10 never produces a strobe
    a_r3_disabled_code: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe[i] |-> ($past(rdData[2*i +: 2]) != 2'b10));

    // R5: capture register holds between strobes
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      !capStrobe[i] |-> $stable(capValue[i*CNT_W +: CNT_W]));

    if (i >= 1 && i <= NUM_BOUND) begin : g_bound
      a_r5_bound_source: assert property (@(posedge clk) disable iff (!rstN)
        capStrobe[i] |-> (capValue[i*CNT_W +: CNT_W] ==
          ($past(rdData[2*NUM_IN + i - 1]) ? $past(cnt1) : $past(cnt0))));
    end else begin : g_fixed
      a_r5_fixed_source: assert property (@(posedge clk) disable iff (!rstN)
        capStrobe[i] |-> (capValue[i*CNT_W +: CNT_W] == $past(cnt0)));
    end
  end
endmodule

bind capture_edge_select cesel_check #(
  .NUM_IN(NUM_IN), .NUM_BOUND(NUM_BOUND), .CNT_W(CNT_W)
) u_cesel_check (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .capIn(capIn), .cnt0(cnt0),
  .cnt1(cnt1), .rdData(rdData), .capStrobe(capStrobe), .capValue(capValue)
);

// File: tb/capture_edge_select_bench.sv
module capture_edge_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [5:0]  capIn = '0;
  logic [15:0] cnt0 = '0;
  logic [15:0] cnt1 = 16'h8000;
  logic [5:0]  capStrobe;
  logic [95:0] capValue;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int toggleRate = 0;
  bit done = 1'b0;

  capture_edge_select u_capture_edge_select (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .cnt0(cnt0),
    .cnt1(cnt1), .capStrobe(capStrobe), .capValue(capValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [15:0] mReg;
  logic [5:0]  mStb;
  logic [15:0] mCap [6];
  logic [5:0]  h1, h2, h3;   // pin samples one, two, three edges back

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = '0; mStb = '0; h1 = '0; h2 = '0; h3 = '0;
      for (int c = 0; c < 6; c++) mCap[c] = '0;
    end else begin
      for (int c = 0; c < 6; c++) begin
        logic [1:0] code;
        logic was, now, hit;
        code = mReg[2*c +: 2];
        was  = h3[c];
        now  = h2[c];
        case (code)
          2'b00: hit = was && !now;
          2'b01: hit = !was && now;
          2'b11: hit = was != now;
          default: hit = 1'b0;
        endcase
        mStb[c] = hit;
        if (hit) begin
          if (c >= 1 && c <= 4 && mReg[11 + c]) mCap[c] = cnt1;
          else mCap[c] = cnt0;
        end
      end
      if (wrEn && (addr == 4'd2 || addr == 4'd3)) begin
        if (byteEn[0]) mReg[7:0]  = wrData[7:0];
        if (byteEn[1]) mReg[15:8] = wrData[15:8];
      end
      h3 = h2; h2 = h1; h1 = capIn;
    end
  end

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  function automatic logic [95:0] packCaps();
    logic [95:0] v;
    for (int c = 0; c < 6; c++) v[16*c +: 16] = mCap[c];
    return v;
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check("R2/R6 register", {80'b0, rdData}, {80'b0, mReg});
      check("R3/R4 strobe", {90'b0, capStrobe}, {90'b0, mStb});
      check("R5 capture", capValue, packCaps());
    end
    cnt0 <= cnt0 + 16'd1;
    cnt1 <= cnt1 + 16'd3;
    if (rstN && toggleRate != 0)
      for (int p = 0; p < 6; p++)
        if (($urandom % 100) < toggleRate) capIn[p] <= ~capIn[p];
  end

  task automatic busWrite(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wrEn <= 1'b1; addr <= a; byteEn <= be; wrData <= d;
    @(negedge clk);
    wrEn <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    compared++;
    if (rdData !== 16'h0 || capStrobe !== 6'h0 || capValue !== 96'h0) begin
      mismatched++;
      $display("FAIL R1 reset: actual %h/%h/%h expected 0", rdData, capStrobe, capValue);
    end
    rstN <= 1'b1;
    idle(2);
    compared++;
    if (rdData !== 16'h0) begin
      mismatched++;
      $display("FAIL R1 after release: actual %h expected 0000", rdData);
    end

    // Default falling mode with pins moving
    toggleRate = 30; idle(60);
    // R3: all rising, then all none, then all both, with binding mixes
    busWrite(4'd2, 2'b11, 16'h0555); idle(60);
    busWrite(4'd2, 2'b11, 16'hFAAA); idle(60);
    busWrite(4'd2, 2'b11, 16'hAFFF); idle(60);
    busWrite(4'd2, 2'b11, 16'h5E4D); idle(60);
    // R2: single-lane writes
    busWrite(4'd2, 2'b01, 16'h33C6); idle(20);
    busWrite(4'd3, 2'b10, 16'hC300); idle(20);
    // R7: ignored writes
    busWrite(4'd0, 2'b11, 16'h1234);
    compared++;
    if (rdData !== mReg) begin
      mismatched++;
      $display("FAIL R7 other address: actual %h expected %h", rdData, mReg);
    end
    busWrite(4'd2, 2'b00, 16'hFFFF);
    compared++;
    if (rdData !== mReg) begin
      mismatched++;
      $display("FAIL R7 no lanes: actual %h expected %h", rdData, mReg);
    end
    // R6: code changes while pins are static create no strobe
    toggleRate = 0; idle(6);
    for (int k = 0; k < 8; k++) begin
      busWrite(4'd2, 2'b11, 16'(k * 16'h2493));
      compared++;
      if (capStrobe !== 6'h0) begin
        mismatched++;
        $display("FAIL R6 spurious strobe: actual %h expected 00", capStrobe);
      end
    end
    // Writes colliding with detections, heavy toggling
    toggleRate = 50;
    for (int k = 0; k < 400; k++) begin
      busWrite(4'(2 + ($urandom % 2)), 2'($urandom), 16'($urandom));
      idle($urandom % 4);
    end
    // R4: single isolated edge, exact strobe timing
    toggleRate = 0;
    busWrite(4'd2, 2'b11, 16'h0001);  // pin 0 rising only
    capIn[0] <= 1'b0; idle(6);
    capIn[0] <= 1'b1; idle(6);
    idle(20);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule